// File: doc/BRIEF.md
# Correlated Load-Branch Pair Selector

This block runs during a training phase beside a core's retire stage. It picks out the few load/branch pairs for which a load's data address is likely to predict a branch outcome. It keeps three tables. The producer table maps each architectural register to the PC of the load that last wrote it. The hard-branch tracker holds the branches that mispredict and adds up the misprediction penalty each one costs. The pair table lists candidate (load PC, branch PC) pairs. Each pair has a saturating savings score for three correlation distances, and the savings come from an external estimator.

Retired loads, retired branches and savings estimates arrive as three valid/ready streams. A branch that is already tracked and retires is joined to the load that produced its source register, and the two become a candidate pair. When training ends, the block pulses through its pair table. For each pair it keeps the distance with the highest saving and sends out the pairs worth keeping as a valid/ready stream, one pair per accepted transfer.

The three input streams are all refused while the readout runs, so their ready outputs are low. The output stream holds its data steady for as long as `sel_ready` is low. A PC value of zero marks an empty table entry throughout the block.

Top module: `ldbr_pair_selector`

## Requirements
- R1: A load accepted on the load stream writes its PC into the producer entry of its destination register. If a branch is accepted in the same cycle, it sees that entry as it was before the write. A register that has never been written reads as PC 0, which means "no producer".
- R2: A branch that is not tracked and retires mispredicted gets a tracker slot, and its counter starts at its penalty. The slot is the lowest-numbered empty slot. If no slot is empty, the slot with the smallest counter is replaced, and among equal counters the lowest-numbered one is taken. A branch PC of 0 is never tracked.
- R3: A tracked branch that retires, mispredicted or not, forms the pair (producer PC of its source register, branch PC), provided that producer PC is nonzero. A pair that is not already present goes into the lowest free slot of the 5-slot pair table. If all five slots are full, the pair is dropped.
- R4: A tracked branch that retires mispredicted adds its 16-bit penalty to its 24-bit counter. The counter saturates at 2^24-1.
- R5: A savings event whose (load PC, branch PC) matches a stored pair adds its 16-bit amount to that pair's counter for distance index `sv_dist` (0, 1 or 2). The counter is 21 bits wide and saturates at 2^21-1. An event with `sv_dist` = 3, or one that matches no stored pair, changes nothing.
- R6: A `train_end` pulse while idle fixes, for each pair, the distance index of its largest savings counter; on a tie the lowest index wins. A pair whose largest counter is 0 is left out of the readout.
- R7: The readout sends the kept pairs in ascending slot order, one per `sel_valid && sel_ready` cycle. `sel_dist` carries the chosen index 0, 1 or 2.
- R8: While `sel_valid` is high and `sel_ready` is low, `sel_valid` stays high and `sel_ld_pc`, `sel_br_pc` and `sel_dist` stay unchanged.
- R9: `sel_busy` rises in the cycle after `train_end` is taken and falls once every slot has been visited. While it is high, `ld_ready`, `br_ready` and `sv_ready` are low. While it is low they are high.
- R10: After reset all three tables are empty, every input ready is high, and `sel_valid` and `sel_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Retired load present |
| ld_ready | output | 1 | Load stream accepted this cycle |
| ld_reg | input | 6 | Destination register of the load |
| ld_pc | input | 32 | Load PC |
| br_valid | input | 1 | Retired branch present |
| br_ready | output | 1 | Branch stream accepted this cycle |
| br_pc | input | 32 | Branch PC |
| br_src_reg | input | 6 | Source register of the branch |
| br_mispred | input | 1 | Branch was mispredicted |
| br_penalty | input | 16 | Cycles lost to the misprediction |
| sv_valid | input | 1 | Savings estimate present |
| sv_ready | output | 1 | Savings stream accepted this cycle |
| sv_ld_pc | input | 32 | Load PC of the estimated pair |
| sv_br_pc | input | 32 | Branch PC of the estimated pair |
| sv_dist | input | 2 | Distance index 0..2 |
| sv_amount | input | 16 | Cycles saved at that distance |
| train_end | input | 1 | Pulse: close training and start the readout |
| sel_valid | output | 1 | Selected pair present |
| sel_ready | input | 1 | Consumer takes the selected pair |
| sel_ld_pc | output | 32 | Selected load PC |
| sel_br_pc | output | 32 | Selected branch PC |
| sel_dist | output | 3 | Chosen correlation distance |
| sel_busy | output | 1 | Readout in progress |

## Verification
The bench drives both saturating counters past full scale. A counter that wrapped would then lose to a mid-range rival: it would pick the wrong distance, or throw out the heaviest branch when a slot is reclaimed. Replacement is tested with one branch holding a smaller counter than the rest. A victim chosen by slot number rather than by counter would keep that branch alive and let a pair form that should not exist. Further cases cover a load and a dependent branch retiring in the same cycle, a duplicate candidate pair, a sixth pair, savings on index 3, and readout under back-pressure. These catch a bypassed producer read, duplicate slots, overflow writes, stray counter updates, and output data that changes while it waits.

// File: rtl/ldbr_pkg.sv
package ldbr_pkg;
  parameter int unsigned LBP_PC_W = 32;
  typedef logic [LBP_PC_W-1:0] pc_t;
  typedef enum logic [0:0] {RD_IDLE, RD_SCAN} rd_state_e;
endpackage

// File: rtl/ldbr_producer_tab.sv
module ldbr_producer_tab
  import ldbr_pkg::*;
#(
  parameter int unsigned NREG = 64,
  localparam int unsigned RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_reg,
  input  pc_t           wr_pc,
  input  logic [RW-1:0] rd_reg,
  output pc_t           rd_pc
);
  pc_t tab_q [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) tab_q[i] <= '0;
    end else if (wr_en) begin
      tab_q[wr_reg] <= wr_pc;
    end
  end

  // read sees the pre-write contents, so a same-cycle branch gets the old producer
  assign rd_pc = tab_q[rd_reg];

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    assert_entry_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_reg == RW'(g)) |=> $stable(tab_q[g]));
  end
endmodule

// File: rtl/ldbr_branch_track.sv
module ldbr_branch_track
  import ldbr_pkg::*;
#(
  parameter int unsigned NBR   = 16,
  parameter int unsigned CNT_W = 24,
  parameter int unsigned PEN_W = 16,
  localparam int unsigned IW   = $clog2(NBR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_en,
  input  pc_t              ev_pc,
  input  logic             ev_mispred,
  input  logic [PEN_W-1:0] ev_pen,
  output logic             hit
);
  pc_t              pc_q  [NBR];
  logic [CNT_W-1:0] cnt_q [NBR];
  logic [NBR-1:0]   hit_vec, free_vec;
  logic [IW-1:0]    hit_idx, free_idx, min_idx, vic_idx;
  logic             any_free, alloc, upd;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_new;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    any_free = 1'b0;
    min_idx  = '0;
    for (int i = 0; i < NBR; i++) begin
      hit_vec[i]  = (pc_q[i] != '0) && (pc_q[i] == ev_pc);
      free_vec[i] = (pc_q[i] == '0);
    end
    for (int i = NBR - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
      if (free_vec[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
    for (int i = 1; i < NBR; i++)
      if (cnt_q[i] < cnt_q[min_idx]) min_idx = IW'(i);
  end

  assign vic_idx = any_free ? free_idx : min_idx;
  assign hit     = ev_en && (ev_pc != '0) && (|hit_vec);
  assign upd     = hit && ev_mispred;
  assign alloc   = ev_en && (ev_pc != '0) && ev_mispred && !(|hit_vec);
  assign sum     = {1'b0, cnt_q[hit_idx]} + (CNT_W+1)'(ev_pen);
  assign cnt_new = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBR; i++) begin
        pc_q[i]  <= '0;
        cnt_q[i] <= '0;
      end
    end else if (upd) begin
      cnt_q[hit_idx] <= cnt_new;
    end else if (alloc) begin
      pc_q[vic_idx]  <= ev_pc;
      cnt_q[vic_idx] <= CNT_W'(ev_pen);
    end
  end

  assert_track_unique_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_en |-> $onehot0(hit_vec));
  for (genvar g = 0; g < NBR; g++) begin : g_chk
    assert_cnt_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(alloc && vic_idx == IW'(g)) |=> cnt_q[g] >= $past(cnt_q[g]));
  end
endmodule

// File: rtl/ldbr_pair_tab.sv
module ldbr_pair_tab
  import ldbr_pkg::*;
#(
  parameter int unsigned NPAIR  = 5,
  parameter int unsigned NDIST  = 3,
  parameter int unsigned SAV_W  = 21,
  parameter int unsigned AMT_W  = 16,
  parameter int unsigned DIST_W = 3,
  localparam int unsigned DSEL_W = $clog2(NDIST),
  localparam int unsigned PIW    = $clog2(NPAIR),
  localparam int unsigned CW     = $clog2(NPAIR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  pc_t               ins_ld_pc,
  input  pc_t               ins_br_pc,
  input  logic              sv_en,
  input  pc_t               sv_ld_pc,
  input  pc_t               sv_br_pc,
  input  logic [DSEL_W-1:0] sv_dist,
  input  logic [AMT_W-1:0]  sv_amt,
  input  logic              latch_en,
  input  logic [CW-1:0]     rd_idx,
  output logic              rd_ok,
  output pc_t               rd_ld_pc,
  output pc_t               rd_br_pc,
  output logic [DIST_W-1:0] rd_dist
);
  pc_t               ld_q   [NPAIR];
  pc_t               br_q   [NPAIR];
  logic [SAV_W-1:0]  sav_q  [NPAIR][NDIST];
  logic [DIST_W-1:0] dist_q [NPAIR];
  logic [SAV_W-1:0]  best_v [NPAIR];
  logic [DIST_W-1:0] best_d [NPAIR];
  logic [NPAIR-1:0]  ins_match, sv_match;
  logic [PIW-1:0]    free_idx, sv_idx, rd_sel;
  logic              any_free, sv_dist_ok;
  logic [DSEL_W-1:0] sv_dist_c;
  logic [SAV_W:0]    ssum;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    sv_idx   = '0;
    for (int i = 0; i < NPAIR; i++) begin
      ins_match[i] = (ld_q[i] != '0) && ld_q[i] == ins_ld_pc && br_q[i] == ins_br_pc;
      sv_match[i]  = (ld_q[i] != '0) && ld_q[i] == sv_ld_pc && br_q[i] == sv_br_pc;
    end
    for (int i = NPAIR - 1; i >= 0; i--) begin
      if (ld_q[i] == '0) begin
        free_idx = PIW'(i);
        any_free = 1'b1;
      end
      if (sv_match[i]) sv_idx = PIW'(i);
    end
    for (int i = 0; i < NPAIR; i++) begin
      best_v[i] = '0;
      best_d[i] = '0;
      for (int d = 0; d < NDIST; d++) begin
        if (sav_q[i][d] > best_v[i]) begin
          best_v[i] = sav_q[i][d];
          best_d[i] = DIST_W'(d);
        end
      end
    end
  end

  assign sv_dist_ok = 32'(sv_dist) < NDIST;
  assign sv_dist_c  = sv_dist_ok ? sv_dist : '0;
  assign ssum       = {1'b0, sav_q[sv_idx][sv_dist_c]} + (SAV_W+1)'(sv_amt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAIR; i++) begin
        ld_q[i]   <= '0;
        br_q[i]   <= '0;
        dist_q[i] <= '0;
        for (int d = 0; d < NDIST; d++) sav_q[i][d] <= '0;
      end
    end else begin
      if (ins_en && ins_ld_pc != '0 && !(|ins_match) && any_free) begin
        ld_q[free_idx] <= ins_ld_pc;
        br_q[free_idx] <= ins_br_pc;
      end
      if (sv_en && (|sv_match) && sv_dist_ok)
        sav_q[sv_idx][sv_dist_c] <= ssum[SAV_W] ? '1 : ssum[SAV_W-1:0];
      if (latch_en)
        for (int i = 0; i < NPAIR; i++) dist_q[i] <= best_d[i];
    end
  end

  assign rd_sel   = (32'(rd_idx) < NPAIR) ? PIW'(rd_idx) : '0;
  assign rd_ok    = (32'(rd_idx) < NPAIR) && ld_q[rd_sel] != '0 && best_v[rd_sel] != '0;
  assign rd_ld_pc = ld_q[rd_sel];
  assign rd_br_pc = br_q[rd_sel];
  assign rd_dist  = dist_q[rd_sel];

  assert_pair_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sv_match));
  for (genvar g = 0; g < NPAIR; g++) begin : g_chk
    for (genvar d = 0; d < NDIST; d++) begin : g_d
      assert_sav_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sav_q[g][d] >= $past(sav_q[g][d]));
    end
  end
endmodule

// File: rtl/ldbr_pair_selector.sv
module ldbr_pair_selector
  import ldbr_pkg::*;
#(
  parameter int unsigned NREG     = 64,
  parameter int unsigned NBR      = 16,
  parameter int unsigned NPAIR    = 5,
  parameter int unsigned NDIST    = 3,
  parameter int unsigned BR_CNT_W = 24,
  parameter int unsigned SAV_W    = 21,
  parameter int unsigned PEN_W    = 16,
  parameter int unsigned DIST_W   = 3,
  localparam int unsigned RW      = $clog2(NREG),
  localparam int unsigned DSEL_W  = $clog2(NDIST),
  localparam int unsigned CW      = $clog2(NPAIR + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_valid,
  output logic                ld_ready,
  input  logic [RW-1:0]       ld_reg,
  input  logic [LBP_PC_W-1:0] ld_pc,
  input  logic                br_valid,
  output logic                br_ready,
  input  logic [LBP_PC_W-1:0] br_pc,
  input  logic [RW-1:0]       br_src_reg,
  input  logic                br_mispred,
  input  logic [PEN_W-1:0]    br_penalty,
  input  logic                sv_valid,
  output logic                sv_ready,
  input  logic [LBP_PC_W-1:0] sv_ld_pc,
  input  logic [LBP_PC_W-1:0] sv_br_pc,
  input  logic [DSEL_W-1:0]   sv_dist,
  input  logic [PEN_W-1:0]    sv_amount,
  input  logic                train_end,
  output logic                sel_valid,
  input  logic                sel_ready,
  output logic [LBP_PC_W-1:0] sel_ld_pc,
  output logic [LBP_PC_W-1:0] sel_br_pc,
  output logic [DIST_W-1:0]   sel_dist,
  output logic                sel_busy
);
  rd_state_e     state_q;
  logic [CW-1:0] idx_q;
  logic          idle, latch_en, br_hit, rd_ok;
  pc_t           prod_pc;

  assign idle     = (state_q == RD_IDLE);
  assign ld_ready = idle;
  assign br_ready = idle;
  assign sv_ready = idle;
  assign sel_busy = !idle;
  assign latch_en = idle && train_end;

  ldbr_producer_tab #(.NREG(NREG)) prod_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ld_valid && idle), .wr_reg(ld_reg), .wr_pc(ld_pc),
    .rd_reg(br_src_reg), .rd_pc(prod_pc)
  );

  ldbr_branch_track #(.NBR(NBR), .CNT_W(BR_CNT_W), .PEN_W(PEN_W)) track_i (
    .clk(clk), .rst_n(rst_n),
    .ev_en(br_valid && idle), .ev_pc(br_pc), .ev_mispred(br_mispred),
    .ev_pen(br_penalty), .hit(br_hit)
  );

  ldbr_pair_tab #(.NPAIR(NPAIR), .NDIST(NDIST), .SAV_W(SAV_W), .AMT_W(PEN_W),
                  .DIST_W(DIST_W)) pair_i (
    .clk(clk), .rst_n(rst_n),
    .ins_en(br_hit && prod_pc != '0), .ins_ld_pc(prod_pc), .ins_br_pc(br_pc),
    .sv_en(sv_valid && idle), .sv_ld_pc(sv_ld_pc), .sv_br_pc(sv_br_pc),
    .sv_dist(sv_dist), .sv_amt(sv_amount),
    .latch_en(latch_en), .rd_idx(idx_q), .rd_ok(rd_ok),
    .rd_ld_pc(sel_ld_pc), .rd_br_pc(sel_br_pc), .rd_dist(sel_dist)
  );

  assign sel_valid = !idle && rd_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      idx_q   <= '0;
    end else if (idle) begin
      if (train_end) begin
        state_q <= RD_SCAN;
        idx_q   <= '0;
      end
    end else if (32'(idx_q) >= NPAIR) begin
      state_q <= RD_IDLE;
    end else if (!rd_ok || sel_ready) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && !sel_ready |=> sel_valid && $stable(sel_ld_pc) && $stable(sel_br_pc)
                                && $stable(sel_dist));
  assert_dist_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> 32'(sel_dist) < NDIST);
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_busy) |-> $past(train_end));
endmodule

// File: tb/ldbr_pair_selector_tb.sv
module ldbr_pair_selector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 0, br_valid = 0, sv_valid = 0, train_end = 0, sel_ready = 1;
  logic        br_mispred = 0;
  logic [5:0]  ld_reg = 0, br_src_reg = 0;
  logic [31:0] ld_pc = 0, br_pc = 0, sv_ld_pc = 0, sv_br_pc = 0;
  logic [15:0] br_penalty = 0, sv_amount = 0;
  logic [1:0]  sv_dist = 0;
  logic        ld_ready, br_ready, sv_ready, sel_valid, sel_busy;
  logic [31:0] sel_ld_pc, sel_br_pc;
  logic [2:0]  sel_dist;

  int checks = 0, failures = 0;
  int got_n;
  logic [31:0] got_ld [8];
  logic [31:0] got_br [8];
  logic [2:0]  got_d  [8];

  always #2.5 clk = ~clk;

  ldbr_pair_selector dut_i (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_reg(ld_reg), .ld_pc(ld_pc),
    .br_valid(br_valid), .br_ready(br_ready), .br_pc(br_pc), .br_src_reg(br_src_reg),
    .br_mispred(br_mispred), .br_penalty(br_penalty),
    .sv_valid(sv_valid), .sv_ready(sv_ready), .sv_ld_pc(sv_ld_pc), .sv_br_pc(sv_br_pc),
    .sv_dist(sv_dist), .sv_amount(sv_amount), .train_end(train_end),
    .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_ld_pc(sel_ld_pc),
    .sel_br_pc(sel_br_pc), .sel_dist(sel_dist), .sel_busy(sel_busy)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ev_load(input logic [5:0] r, input logic [31:0] pc);
    ld_valid = 1; ld_reg = r; ld_pc = pc;
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic ev_br(input logic [31:0] pc, input logic [5:0] src, input logic mis,
                       input logic [15:0] pen);
    br_valid = 1; br_pc = pc; br_src_reg = src; br_mispred = mis; br_penalty = pen;
    @(negedge clk);
    br_valid = 0; br_mispred = 0;
  endtask

  task automatic ev_sav(input logic [31:0] lpc, input logic [31:0] bpc,
                        input logic [1:0] d, input logic [15:0] amt);
    sv_valid = 1; sv_ld_pc = lpc; sv_br_pc = bpc; sv_dist = d; sv_amount = amt;
    @(negedge clk);
    sv_valid = 0;
  endtask

  task automatic run_readout();
    got_n = 0;
    sel_ready = 1;
    train_end = 1;
    @(negedge clk);
    train_end = 0;
    for (int c = 0; c < 40; c++) begin
      if (!sel_busy) break;
      if (sel_valid && sel_ready && got_n < 8) begin
        got_ld[got_n] = sel_ld_pc; got_br[got_n] = sel_br_pc; got_d[got_n] = sel_dist;
        got_n++;
      end
      @(negedge clk);
    end
    chk("R9", "busy cleared after scan", 64'(sel_busy), 64'd0);
  endtask

  function automatic logic [31:0] bpc(input int i);
    return 32'h0000_4000 + 32'(i * 4);
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R10", "ld_ready", 64'(ld_ready), 1);
    chk("R10", "br_ready", 64'(br_ready), 1);
    chk("R10", "sv_ready", 64'(sv_ready), 1);
    chk("R10", "sel_valid", 64'(sel_valid), 0);
    chk("R10", "sel_busy", 64'(sel_busy), 0);
    run_readout();
    chk("R10", "empty table yields no pairs", 64'(got_n), 0);
  endtask

  task automatic t_basic();
    do_reset();
    ev_load(6'd5, 32'h8000_0010);
    ev_br(32'h1000, 6'd5, 1, 16'd40);
    ev_br(32'h1000, 6'd5, 0, 16'd0);
    ev_sav(32'h8000_0010, 32'h1000, 2'd1, 16'd100);
    run_readout();
    chk("R3", "pair count", 64'(got_n), 1);
    chk("R1", "load pc", 64'(got_ld[0]), 64'h8000_0010);
    chk("R7", "branch pc", 64'(got_br[0]), 64'h1000);
    chk("R6", "distance", 64'(got_d[0]), 1);
  endtask

  task automatic t_tie_and_zero();
    do_reset();
    ev_load(6'd2, 32'h8000_0020);
    ev_br(32'h2000, 6'd2, 1, 16'd5);
    ev_br(32'h2000, 6'd2, 0, 16'd0);
    ev_br(32'h2100, 6'd2, 1, 16'd5);
    ev_br(32'h2100, 6'd2, 0, 16'd0);
    ev_sav(32'h8000_0020, 32'h2000, 2'd2, 16'd50);
    ev_sav(32'h8000_0020, 32'h2000, 2'd1, 16'd10);
    ev_sav(32'h8000_0020, 32'h2000, 2'd0, 16'd50);
    run_readout();
    chk("R6", "zero-saving pair dropped", 64'(got_n), 1);
    chk("R6", "tie picks lowest index", 64'(got_d[0]), 0);
  endtask

  task automatic t_sav_sat();
    do_reset();
    ev_load(6'd3, 32'h8000_0030);
    ev_br(32'h3000, 6'd3, 1, 16'd1);
    ev_br(32'h3000, 6'd3, 0, 16'd0);
    for (int k = 0; k < 33; k++) ev_sav(32'h8000_0030, 32'h3000, 2'd0, 16'hFFFF);
    for (int k = 0; k < 30; k++) ev_sav(32'h8000_0030, 32'h3000, 2'd1, 16'hFFFF);
    ev_sav(32'h8000_0030, 32'h3000, 2'd1, 16'd33950);
    run_readout();
    chk("R5", "pair count", 64'(got_n), 1);
    chk("R5", "saturated counter still wins", 64'(got_d[0]), 0);
  endtask

  task automatic t_bad_dist();
    do_reset();
    ev_load(6'd4, 32'h8000_0040);
    ev_br(32'h4400, 6'd4, 1, 16'd1);
    ev_br(32'h4400, 6'd4, 0, 16'd0);
    ev_sav(32'h8000_0040, 32'h4400, 2'd3, 16'd100);
    ev_sav(32'h8000_0044, 32'h4400, 2'd0, 16'd100);
    run_readout();
    chk("R5", "index 3 and unmatched savings ignored", 64'(got_n), 0);
  endtask

  task automatic t_br_sat();
    logic [31:0] x;
    x = 32'h7000;
    do_reset();
    for (int k = 0; k < 260; k++) ev_br(x, 6'd0, 1, 16'hFFFF);
    for (int i = 1; i < 16; i++)
      for (int k = 0; k < 5; k++) ev_br(bpc(i), 6'd0, 1, 16'hFFFF);
    ev_br(32'h7100, 6'd0, 1, 16'd1);
    ev_load(6'd7, 32'h8000_0070);
    ev_br(x, 6'd7, 0, 16'd0);
    ev_br(bpc(1), 6'd7, 0, 16'd0);
    ev_sav(32'h8000_0070, x, 2'd0, 16'd5);
    ev_sav(32'h8000_0070, bpc(1), 2'd0, 16'd5);
    run_readout();
    chk("R4", "saturated branch kept, one pair", 64'(got_n), 1);
    chk("R4", "surviving branch", 64'(got_br[0]), 64'(x));
    chk("R1", "never-loaded register gave no pair", 64'(got_ld[0]), 64'h8000_0070);
  endtask

  task automatic t_evict();
    do_reset();
    for (int i = 0; i < 16; i++) ev_br(bpc(i), 6'd0, 1, (i == 5) ? 16'd10 : 16'(100 + i));
    ev_br(32'h9000, 6'd0, 1, 16'd50);
    ev_load(6'd9, 32'h8000_0090);
    ev_br(bpc(5), 6'd9, 0, 16'd0);
    ev_br(bpc(6), 6'd9, 0, 16'd0);
    ev_br(32'h9000, 6'd9, 0, 16'd0);
    ev_sav(32'h8000_0090, bpc(5), 2'd1, 16'd3);
    ev_sav(32'h8000_0090, bpc(6), 2'd1, 16'd3);
    ev_sav(32'h8000_0090, 32'h9000, 2'd2, 16'd3);
    run_readout();
    chk("R2", "pair count after min eviction", 64'(got_n), 2);
    chk("R2", "first pair branch", 64'(got_br[0]), 64'(bpc(6)));
    chk("R2", "new branch tracked", 64'(got_br[1]), 64'h9000);
    chk("R6", "new branch distance", 64'(got_d[1]), 2);
  endtask

  task automatic t_full();
    do_reset();
    ev_br(32'hA000, 6'd0, 1, 16'd1);
    for (int j = 1; j <= 6; j++) begin
      ev_load(6'd2, 32'h8100_0000 + 32'(j));
      ev_br(32'hA000, 6'd2, 0, 16'd0);
      if (j == 2) begin
        ev_load(6'd2, 32'h8100_0001);
        ev_br(32'hA000, 6'd2, 0, 16'd0);
      end
    end
    for (int j = 1; j <= 6; j++) ev_sav(32'h8100_0000 + 32'(j), 32'hA000, 2'd0, 16'd1);
    run_readout();
    chk("R3", "table holds five pairs", 64'(got_n), 5);
    for (int j = 0; j < 5; j++)
      chk("R7", "slot order load pc", 64'(got_ld[j]), 64'(32'h8100_0001 + 32'(j)));
  endtask

  task automatic t_backpressure();
    logic [31:0] l0;
    do_reset();
    ev_load(6'd1, 32'h8000_00B0);
    ev_br(32'hB000, 6'd1, 1, 16'd1);
    ev_br(32'hB000, 6'd1, 0, 16'd0);
    ev_sav(32'h8000_00B0, 32'hB000, 2'd2, 16'd9);
    sel_ready = 0;
    train_end = 1;
    @(negedge clk);
    train_end = 0;
    chk("R9", "busy after train_end", 64'(sel_busy), 1);
    chk("R9", "load stream blocked", 64'(ld_ready), 0);
    chk("R9", "savings stream blocked", 64'(sv_ready), 0);
    l0 = sel_ld_pc;
    for (int c = 0; c < 4; c++) begin
      chk("R8", "valid held", 64'(sel_valid), 1);
      chk("R8", "load pc held", 64'(sel_ld_pc), 64'h8000_00B0);
      @(negedge clk);
    end
    chk("R8", "data stable", 64'(sel_ld_pc), 64'(l0));
    chk("R8", "distance", 64'(sel_dist), 2);
    sel_ready = 1;
    for (int c = 0; c < 20 && sel_busy; c++) @(negedge clk);
    chk("R9", "ready restored", 64'(br_ready), 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    ev_load(6'd3, 32'h8000_00C0);
    ev_br(32'hC000, 6'd3, 1, 16'd1);
    ld_valid = 1; ld_reg = 6'd3; ld_pc = 32'h8000_00C8;
    br_valid = 1; br_pc = 32'hC000; br_src_reg = 6'd3; br_mispred = 0;
    @(negedge clk);
    ld_valid = 0; br_valid = 0;
    ev_sav(32'h8000_00C0, 32'hC000, 2'd2, 16'd7);
    ev_sav(32'h8000_00C8, 32'hC000, 2'd0, 16'd9);
    run_readout();
    chk("R1", "one pair", 64'(got_n), 1);
    chk("R1", "old producer used", 64'(got_ld[0]), 64'h8000_00C0);
    chk("R1", "distance", 64'(got_d[0]), 2);
  endtask

  initial begin
    #(100000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_tie_and_zero();
    t_sav_sat();
    t_bad_dist();
    t_br_sat();
    t_evict();
    t_full();
    t_backpressure();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule